// File: doc/BRIEF.md
# Transform Frame Synchronizer

This block sits in front of an FFT engine and decides which incoming complex sample opens each transform vector. Every input word carries a 16-bit in-phase part, a 16-bit quadrature part and one parity bit. Software arms the unit. The first external timing tick after arming fixes the phase of the framing. From then on the unit free-runs and labels every valid sample with its position inside the vector. On the first position it raises a vector-start strobe. This continues until a stop command arrives.

Two units can be fed the same sample stream to get overlapped transforms. One unit runs with the half-offset control clear. The other has it set, so it discards half a vector of samples after the tick before it opens its first vector. The two sets of transforms are then offset by 50%. The vector length is a power of two from 2 to 256 points. Parity is checked on every sample, and a sticky flag records any mismatch.

States are `S_IDLE`, `S_ARMED`, `S_HOLD` and `S_RUN`. The transitions are as follows:
- arm moves `S_IDLE` to `S_ARMED`.
- A tick moves `S_ARMED` to `S_RUN` when half-offset is clear, or to `S_HOLD` when it is set.
- The last discarded sample moves `S_HOLD` to `S_RUN`.
- stop returns any state to `S_IDLE`.

Top module: `frame_sync`

## Requirements
- R1: A valid word has good parity when the XOR of all 33 bits (`smp_i`, `smp_q`, `smp_par`) is 0. Any valid word with odd total parity sets `par_err` at the next clock edge, in every state. Words with `smp_valid` low are not checked. `par_err` stays set until `err_clr` is high on a cycle with no new error; a new error in the same cycle as `err_clr` wins.
- R2: After reset the unit is in `S_IDLE`, with `frm_valid`, `frm_start`, `frm_idx`, `running` and `par_err` all 0.
- R3: A tick while the unit is in `S_IDLE` is ignored; no samples are framed afterwards. An arm pulse moves `S_IDLE` to `S_ARMED`.
- R4: In `S_ARMED` with `half_off` = 0, a tick moves the unit to `S_RUN`. The sample in the tick cycle is not framed, and the next valid sample gets index 0 with `frm_start` = 1.
- R5: In `S_RUN` each valid sample is framed with an index one higher than the previous framed sample. Index N-1 is followed by 0, and every index 0 carries `frm_start`. Cycles with `smp_valid` low do not advance the index, and further ticks have no effect.
- R6: With `half_off` = 1 at the tick, the next N/2 valid samples are discarded (`S_HOLD`). The valid sample after them gets index 0 and `frm_start`.
- R7: `len_log2` = k selects N = 2^k for k in 1..8. A value of 0 acts as 1 (N = 2), and values above 8 act as 8 (N = 256). The length is loaded only while in `S_IDLE`; changes in any other state have no effect until the next stop.
- R8: stop returns the unit to `S_IDLE` from the next cycle, from any state. A sample in the stop cycle is still framed. stop overrides an arm pulse in the same cycle.
- R9: Framed outputs (`frm_valid`, `frm_idx`, `frm_start`, `frm_i`, `frm_q`) appear one clock after their input sample. `frm_i`/`frm_q` are copies of that sample's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample present this cycle |
| smp_i | input | 16 | In-phase sample |
| smp_q | input | 16 | Quadrature sample |
| smp_par | input | 1 | Parity bit making the word's total parity even |
| tick | input | 1 | External timing tick |
| arm | input | 1 | Arm pulse |
| stop | input | 1 | Stop command |
| half_off | input | 1 | Delay the first vector by half a vector |
| len_log2 | input | 4 | log2 of vector length |
| err_clr | input | 1 | Clear the parity error flag |
| frm_valid | output | 1 | A framed sample is on the outputs |
| frm_start | output | 1 | Framed sample is the first of a vector |
| frm_idx | output | 8 | Position of the framed sample in its vector |
| frm_i | output | 16 | In-phase data of the framed sample |
| frm_q | output | 16 | Quadrature data of the framed sample |
| running | output | 1 | Unit is in `S_RUN` |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The bench checks the following cases. The sample in the tick cycle itself must not be framed; a design that framed it would put every vector one sample early. Ticks in the wrong state are probed: ticks before arming would start framing on their own, and ticks during a run would re-phase the vectors. The hold-off count is tested at N = 8 and at the clamped minimum N = 2, where an off-by-one would skip 0 or 2 samples instead of 1. A 256-point run shows the clamp of oversized lengths, and a length change in mid-run must not alter the wrap point. Parity is tested for a set-versus-clear race and for bad words with `smp_valid` low.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_HOLD  = 2'd2,
        S_RUN   = 2'd3
    } fs_state_e;
endpackage

// File: rtl/fs_parity.sv
module fs_parity #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    input  logic          in_par,
    input  logic          err_clr,
    output logic          err
);
    logic bad;

    // odd total parity on a presented word is an error
    assign bad = in_valid && (^{in_i, in_q, in_par});

    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (bad)     err <= 1'b1;
        else if (err_clr) err <= 1'b0;
    end

    // R1: a bad word always leaves the flag set
    a_r1_bad_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> err);
    // R1: without a clear the flag never drops
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
    import frame_sync_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IDXW = 8,
    parameter int LGW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_i,
    input  logic [DW-1:0]   in_q,
    input  logic            tick,
    input  logic            arm,
    input  logic            stop,
    input  logic            half_off,
    input  logic [LGW-1:0]  len_lg,
    output logic            out_valid,
    output logic            vec_start,
    output logic [IDXW-1:0] out_idx,
    output logic [DW-1:0]   out_i,
    output logic [DW-1:0]   out_q,
    output logic            running
);
    localparam int MAXLG = IDXW;

    fs_state_e       st_q, st_d;
    logic [LGW-1:0]  lg_clamp, lg_q;
    logic [IDXW-1:0] mask, half_last, cnt_q, cnt_d;
    logic            take;

    // legal length range is 2^1 .. 2^MAXLG
    always_comb begin
        if (len_lg == '0)                  lg_clamp = LGW'(1);
        else if (len_lg > LGW'(MAXLG))     lg_clamp = LGW'(MAXLG);
        else                               lg_clamp = len_lg;
    end

    assign mask      = {IDXW{1'b1}} >> (IDXW - int'(lg_q));
    assign half_last = mask >> 1;
    assign take      = (st_q == S_RUN) && in_valid;
    assign running   = (st_q == S_RUN);

    // next-state and position counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (stop) begin
            st_d  = S_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                S_IDLE:  if (arm) st_d = S_ARMED;
                S_ARMED: if (tick) begin
                    cnt_d = '0;
                    st_d  = half_off ? S_HOLD : S_RUN;
                end
                S_HOLD:  if (in_valid) begin
                    if (cnt_q == half_last) begin
                        cnt_d = '0;
                        st_d  = S_RUN;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_RUN:   if (in_valid) cnt_d = (cnt_q == mask) ? '0 : cnt_q + 1'b1;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            lg_q  <= LGW'(1);
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == S_IDLE) lg_q <= lg_clamp;
        end
    end

    // framed outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            vec_start <= 1'b0;
            out_idx   <= '0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= take;
            vec_start <= take && (cnt_q == '0);
            out_idx   <= take ? cnt_q : '0;
            if (take) begin
                out_i <= in_i;
                out_q <= in_q;
            end
        end
    end

    // R3: from idle only arming is possible
    a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |=> (st_q == S_IDLE || st_q == S_ARMED));
    // R4: R6: every run begins at position zero
    a_r4_run_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_RUN) && ($past(st_q) != S_RUN)) |-> (cnt_q == '0));
    // R5: indices stay inside the vector
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx <= mask));
    // R7: length frozen outside idle
    a_r7_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |=> $stable(lg_q));
    // R8: stop always lands in idle
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (st_q == S_IDLE));
endmodule

// File: rtl/frame_sync.sv
module frame_sync #(
    parameter int DW   = 16,
    parameter int IDXW = 8,
    parameter int LGW  = $clog2(IDXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [DW-1:0]   smp_i,
    input  logic [DW-1:0]   smp_q,
    input  logic            smp_par,
    input  logic            tick,
    input  logic            arm,
    input  logic            stop,
    input  logic            half_off,
    input  logic [LGW-1:0]  len_log2,
    input  logic            err_clr,
    output logic            frm_valid,
    output logic            frm_start,
    output logic [IDXW-1:0] frm_idx,
    output logic [DW-1:0]   frm_i,
    output logic [DW-1:0]   frm_q,
    output logic            running,
    output logic            par_err
);
    fs_parity #(.DW(DW)) u_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (smp_valid),
        .in_i     (smp_i),
        .in_q     (smp_q),
        .in_par   (smp_par),
        .err_clr  (err_clr),
        .err      (par_err)
    );

    fs_ctrl #(.DW(DW), .IDXW(IDXW), .LGW(LGW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_i      (smp_i),
        .in_q      (smp_q),
        .tick      (tick),
        .arm       (arm),
        .stop      (stop),
        .half_off  (half_off),
        .len_lg    (len_log2),
        .out_valid (frm_valid),
        .vec_start (frm_start),
        .out_idx   (frm_idx),
        .out_i     (frm_i),
        .out_q     (frm_q),
        .running   (running)
    );
endmodule

// File: tb/frame_sync_bench.sv
`timescale 1ns/1ps
module frame_sync_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_i = '0, smp_q = '0;
    logic        smp_par = 1'b0;
    logic        tick = 1'b0, arm = 1'b0, stop = 1'b0, half_off = 1'b0;
    logic [3:0]  len_log2 = 4'd3;
    logic        err_clr = 1'b0;
    logic        frm_valid, frm_start, running, par_err;
    logic [7:0]  frm_idx;
    logic [15:0] frm_i, frm_q;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frame_sync u_frame_sync (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i),
        .smp_q(smp_q), .smp_par(smp_par), .tick(tick), .arm(arm),
        .stop(stop), .half_off(half_off), .len_log2(len_log2),
        .err_clr(err_clr), .frm_valid(frm_valid), .frm_start(frm_start),
        .frm_idx(frm_idx), .frm_i(frm_i), .frm_q(frm_q),
        .running(running), .par_err(par_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // present a good-parity sample with given data
    task automatic load(input logic [15:0] d);
        smp_valid = 1'b1;
        smp_i     = d;
        smp_q     = d ^ 16'h5A3C;
        smp_par   = ^{d, d ^ 16'h5A3C};
    endtask

    // one sample expected to be framed at position idx
    task automatic framed(input logic [15:0] d, input int idx, input string tag);
        load(d);
        step();
        chk({tag, " valid"}, int'(frm_valid), 1);
        chk({tag, " idx"},   int'(frm_idx), idx);
        chk({tag, " start"}, int'(frm_start), (idx == 0) ? 1 : 0);
        smp_valid = 1'b0;
    endtask

    task automatic unframed(input logic [15:0] d, input string tag);
        load(d);
        step();
        chk({tag, " not framed"}, int'(frm_valid), 0);
        smp_valid = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1; step(); arm = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; step(); stop = 1'b0; step();
        chk("R8 stopped", int'(running), 0);
    endtask

    task automatic t_reset();
        chk("R2 valid", int'(frm_valid), 0);
        chk("R2 start", int'(frm_start), 0);
        chk("R2 idx", int'(frm_idx), 0);
        chk("R2 running", int'(running), 0);
        chk("R2 par_err", int'(par_err), 0);
    endtask

    task automatic t_idle_tick();
        tick = 1'b1; load(16'h0011); step(); tick = 1'b0; smp_valid = 1'b0;
        for (int k = 0; k < 3; k++) unframed(16'h0020 + 16'(k), "R3 idle tick");
        chk("R3 idle running", int'(running), 0);
    endtask

    task automatic t_basic();
        int idx;
        len_log2 = 4'd3;
        do_arm();
        tick = 1'b1; load(16'h0100); step(); tick = 1'b0; smp_valid = 1'b0;
        chk("R4 tick sample not framed", int'(frm_valid), 0);
        chk("R4 running", int'(running), 1);
        idx = 0;
        for (int k = 0; k < 5; k++) begin
            framed(16'h0200 + 16'(k), idx, "R4 R5 run");
            idx = (idx + 1) % 8;
        end
        chk("R9 data i", int'(frm_i), 16'h0204);
        chk("R9 data q", int'(frm_q), 16'h0204 ^ 16'h5A3C);
        step();
        chk("R5 gap no output", int'(frm_valid), 0);
        tick = 1'b1; len_log2 = 4'd1;
        framed(16'h0300, idx, "R5 R7 tick and length ignored");
        tick = 1'b0;
        idx = (idx + 1) % 8;
        for (int k = 0; k < 10; k++) begin
            framed(16'h0400 + 16'(k), idx, "R5 R7 wrap at 8");
            idx = (idx + 1) % 8;
        end
        stop = 1'b1;
        framed(16'h0500, idx, "R8 stop-cycle sample");
        stop = 1'b0;
        unframed(16'h0501, "R8 after stop");
        chk("R8 running", int'(running), 0);
        len_log2 = 4'd3;
    endtask

    task automatic t_half(input logic [3:0] lg, input int n, input string tag);
        len_log2 = lg; half_off = 1'b1;
        do_arm();
        tick = 1'b1; step(); tick = 1'b0; half_off = 1'b0;
        for (int k = 0; k < n / 2; k++) unframed(16'h0600 + 16'(k), {tag, " hold"});
        for (int k = 0; k < n + 2; k++) framed(16'h0700 + 16'(k), k % n, {tag, " run"});
        do_stop();
    endtask

    task automatic t_big();
        len_log2 = 4'd12;
        do_arm();
        tick = 1'b1; step(); tick = 1'b0;
        for (int k = 0; k < 258; k++) framed(16'(k), k % 256, "R7 clamp 256");
        do_stop();
        len_log2 = 4'd3;
    endtask

    task automatic t_stop_arm();
        arm = 1'b1; stop = 1'b1; step(); arm = 1'b0; stop = 1'b0;
        tick = 1'b1; step(); tick = 1'b0;
        unframed(16'h0800, "R8 stop beats arm");
    endtask

    task automatic t_parity();
        load(16'h1234); step(); smp_valid = 1'b0;
        chk("R1 good word", int'(par_err), 0);
        load(16'h1234); smp_par = ~smp_par; step(); smp_valid = 1'b0;
        chk("R1 bad word sets", int'(par_err), 1);
        step(); step();
        chk("R1 sticky", int'(par_err), 1);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        chk("R1 cleared", int'(par_err), 0);
        load(16'h0F0F); smp_par = ~smp_par; err_clr = 1'b1; step();
        err_clr = 1'b0; smp_valid = 1'b0;
        chk("R1 set beats clear", int'(par_err), 1);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        load(16'h0F0F); smp_par = ~smp_par; smp_valid = 1'b0; step();
        chk("R1 invalid word unchecked", int'(par_err), 0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_tick();
        t_basic();
        t_half(4'd3, 8, "R6 N=8");
        t_half(4'd0, 2, "R6 R7 N=2");
        t_big();
        t_stop_arm();
        t_parity();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule